// File: doc/BRIEF.md
# Beat-Period Jitter Monitor

This block measures the timing jitter of a free-running clock by coherent sampling. A second clock, whose period is only slightly different, samples the clock under test in a capture flip-flop. Because the two periods are so close, the sampled value changes only rarely, and the result is a slow beat waveform. Every high or low stretch of that beat covers a whole number of sampling-clock cycles. The jitter on both clocks makes that number vary from one stretch to the next, and the spread of the numbers is the quantity of interest.

The monitor runs entirely on the sampling clock. It resynchronizes the beat, finds its transitions and counts the length of each half-period. The raw length is shown on every transition, together with a one-cycle strobe. After a start pulse, the monitor collects a programmed number of lengths and accumulates three values: the sample count, the sum of the lengths and the sum of their squares. From these, software derives the mean and the standard deviation. The square root and the conversion to picoseconds are left to software.

Top module: `beat_jitter_monitor`

## Requirements
- R1: After a synchronous active-high reset, `cnt_out`, `cnt_valid`, `overflow`, `acc_n`, `acc_sum`, `acc_sq` and `done` are all zero.
- R2: On each beat transition, `cnt_out` shows the number of sampling-clock cycles for which the clock under test was sampled at the level that just ended. This holds for both high and low half-periods.
- R3: `cnt_valid` is a single-cycle pulse, given once per beat transition. The first transition after reset, or after `start`, gives no pulse, because the half-period before it is only partly observed.
- R4: A half-period longer than 255 cycles saturates the count at 255 and sets `overflow`. `overflow` stays set until `start` or reset. Such a sample is not accumulated. A half-period of exactly 255 cycles is an ordinary sample.
- R5: `start` clears `acc_n`, `acc_sum`, `acc_sq`, `done` and `overflow`, and it latches `pop_target` as the population size.
- R6: While collecting, each accepted sample adds 1 to `acc_n`, its length to `acc_sum` and the square of its length to `acc_sq`.
- R7: `done` rises in the same cycle in which the accumulators take in the sample that makes `acc_n` equal to the latched target. After that, further transitions still update `cnt_out`, but they leave all accumulators unchanged until the next `start`.
- R8: A latched target of zero sets `done` within two cycles of `start`, and all accumulators stay at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Sampling clock; clocks every register in the block |
| rst | input | 1 | Synchronous active-high reset |
| tst_clk | input | 1 | Clock under test, used only as data for the capture flip-flop |
| start | input | 1 | One-cycle pulse that begins a new collection |
| pop_target | input | 16 | Number of samples to collect, latched on `start` |
| cnt_out | output | 8 | Length of the last completed beat half-period |
| cnt_valid | output | 1 | One-cycle strobe marking a new `cnt_out` |
| overflow | output | 1 | Sticky flag: a half-period exceeded 255 cycles |
| acc_n | output | 16 | Number of samples accumulated |
| acc_sum | output | 24 | Sum of the accumulated lengths |
| acc_sq | output | 32 | Sum of the squared accumulated lengths |
| done | output | 1 | The programmed population has been collected |

## Verification
The assertions assume that every beat level lasts at least two sampling cycles. In that case strobes are never adjacent and no reported length is zero. This holds in practice, because the two clock periods differ only slightly. The assertions also assume that `start` is a single-cycle pulse. The bench drives the clock under test as a level that is held for a chosen number of sampling cycles, always three or more. It changes the level and `start` on the falling edge, so each level is seen by exactly the intended number of capture edges.

// File: rtl/jm_pkg.sv
package jm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_t;

    typedef struct packed {
        logic level;
        logic toggled;
    } beat_evt_t;

endpackage

// File: rtl/beat_sync.sv
module beat_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              raw,
    output jm_pkg::beat_evt_t evt
);
    // chain[0] is the capture flop; the rest resynchronize it
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= raw;
    end

    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= 1'b0;
            else     chain[i] <= chain[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[SYNC_STAGES-1];
    end

    always_comb begin
        evt.level   = chain[SYNC_STAGES-1];
        evt.toggled = chain[SYNC_STAGES-1] ^ prev;
    end
endmodule

// File: rtl/beat_period_counter.sv
module beat_period_counter #(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  jm_pkg::beat_evt_t evt,
    output logic [CNT_W-1:0]  len_q,
    output logic              len_valid,
    output logic              len_sat,
    output logic              ovf
);
    localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] run;
    logic             seg_sat;
    logic             have_ref;

    always_ff @(posedge clk) begin
        if (rst) begin
            run       <= '0;
            seg_sat   <= 1'b0;
            have_ref  <= 1'b0;
            len_q     <= '0;
            len_valid <= 1'b0;
            len_sat   <= 1'b0;
            ovf       <= 1'b0;
        end else begin
            len_valid <= 1'b0;
            if (evt.toggled) begin
                len_q     <= run;
                len_sat   <= seg_sat;
                len_valid <= have_ref & ~start;
                run       <= {{(CNT_W-1){1'b0}}, 1'b1};
                seg_sat   <= 1'b0;
                have_ref  <= 1'b1;
            end else begin
                if (start) have_ref <= 1'b0;
                if (run == RUN_MAX) begin
                    seg_sat <= 1'b1;
                    ovf     <= 1'b1;
                end else begin
                    run <= run + 1'b1;
                end
            end
            if (start) ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/beat_stats_acc.sv
module beat_stats_acc #(
    parameter int CNT_W = 8,
    parameter int POP_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [POP_W-1:0]          target,
    input  logic                      smp_valid,
    input  logic                      smp_sat,
    input  logic [CNT_W-1:0]          smp_len,
    output logic [POP_W-1:0]          n_q,
    output logic [CNT_W+POP_W-1:0]    sum_q,
    output logic [2*CNT_W+POP_W-1:0]  sq_q,
    output logic                      done
);
    import jm_pkg::*;

    localparam int SUM_W = CNT_W + POP_W;
    localparam int SQ_W  = 2*CNT_W + POP_W;

    phase_t             phase;
    logic [POP_W-1:0]   tgt_q;
    logic [2*CNT_W-1:0] prod;
    logic [POP_W-1:0]   n_next;
    logic               take;

    always_comb begin
        prod   = (2*CNT_W)'(smp_len) * (2*CNT_W)'(smp_len);
        n_next = n_q + 1'b1;
        take   = (phase == PH_RUN) && smp_valid && !smp_sat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            tgt_q <= '0;
            n_q   <= '0;
            sum_q <= '0;
            sq_q  <= '0;
        end else if (start) begin
            phase <= PH_RUN;
            tgt_q <= target;
            n_q   <= '0;
            sum_q <= '0;
            sq_q  <= '0;
        end else if (phase == PH_RUN) begin
            if (tgt_q == '0) begin
                phase <= PH_DONE;
            end else if (take) begin
                n_q   <= n_next;
                sum_q <= sum_q + SUM_W'(smp_len);
                sq_q  <= sq_q + SQ_W'(prod);
                if (n_next == tgt_q) phase <= PH_DONE;
            end
        end
    end

    assign done = (phase == PH_DONE);
endmodule

// File: rtl/beat_jitter_monitor.sv
module beat_jitter_monitor #(
    parameter int CNT_W       = 8,
    parameter int POP_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                              clk_smp,
    input  logic                              rst,
    input  logic                              tst_clk,
    input  logic                              start,
    input  logic [POP_W-1:0]                  pop_target,
    output logic [CNT_W-1:0]                  cnt_out,
    output logic                              cnt_valid,
    output logic                              overflow,
    output logic [POP_W-1:0]                  acc_n,
    output logic [CNT_W+POP_W-1:0]            acc_sum,
    output logic [2*CNT_W+POP_W-1:0]          acc_sq,
    output logic                              done
);
    jm_pkg::beat_evt_t evt;
    logic              len_sat;

    beat_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk (clk_smp),
        .rst (rst),
        .raw (tst_clk),
        .evt (evt)
    );

    beat_period_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk_smp),
        .rst       (rst),
        .start     (start),
        .evt       (evt),
        .len_q     (cnt_out),
        .len_valid (cnt_valid),
        .len_sat   (len_sat),
        .ovf       (overflow)
    );

    beat_stats_acc #(.CNT_W(CNT_W), .POP_W(POP_W)) u_acc (
        .clk       (clk_smp),
        .rst       (rst),
        .start     (start),
        .target    (pop_target),
        .smp_valid (cnt_valid),
        .smp_sat   (len_sat),
        .smp_len   (cnt_out),
        .n_q       (acc_n),
        .sum_q     (acc_sum),
        .sq_q      (acc_sq),
        .done      (done)
    );
endmodule

// File: rtl/beat_jitter_monitor_chk.sv
module beat_jitter_monitor_chk #(
    parameter int CNT_W = 8,
    parameter int POP_W = 16
) (
    input logic                         clk_smp,
    input logic                         rst,
    input logic                         start,
    input logic [CNT_W-1:0]             cnt_out,
    input logic                         cnt_valid,
    input logic                         overflow,
    input logic [POP_W-1:0]             acc_n,
    input logic [CNT_W+POP_W-1:0]       acc_sum,
    input logic [2*CNT_W+POP_W-1:0]     acc_sq,
    input logic                         done
);
    AST_LEN_NONZERO: assert property (@(posedge clk_smp) disable iff (rst)
        cnt_valid |-> cnt_out != '0); // R2

    AST_VALID_SINGLE: assert property (@(posedge clk_smp) disable iff (rst)
        cnt_valid |=> !cnt_valid); // R3

    AST_OVF_STICKY: assert property (@(posedge clk_smp) disable iff (rst)
        (overflow && !start) |=> overflow); // R4

    AST_START_CLEARS: assert property (@(posedge clk_smp) disable iff (rst)
        start |=> (acc_n == '0 && acc_sum == '0 && acc_sq == '0 && !done && !overflow)); // R5

    AST_N_STEP: assert property (@(posedge clk_smp) disable iff (rst)
        !start |=> (acc_n == $past(acc_n) || acc_n == $past(acc_n) + 1'b1)); // R6

    AST_SUM_TRACKS_N: assert property (@(posedge clk_smp) disable iff (rst)
        !start |=> ((acc_n == $past(acc_n)) == (acc_sum == $past(acc_sum)))); // R6

    AST_DONE_FREEZE: assert property (@(posedge clk_smp) disable iff (rst)
        (done && !start) |=> (done && $stable(acc_n) && $stable(acc_sum) && $stable(acc_sq))); // R7
endmodule

bind beat_jitter_monitor beat_jitter_monitor_chk #(.CNT_W(CNT_W), .POP_W(POP_W)) u_chk (
    .clk_smp   (clk_smp),
    .rst       (rst),
    .start     (start),
    .cnt_out   (cnt_out),
    .cnt_valid (cnt_valid),
    .overflow  (overflow),
    .acc_n     (acc_n),
    .acc_sum   (acc_sum),
    .acc_sq    (acc_sq),
    .done      (done)
);

// File: tb/beat_jitter_monitor_test.sv
`timescale 1ns/1ps
module beat_jitter_monitor_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        tst_clk;
    logic        start;
    logic [15:0] pop_target;
    logic [7:0]  cnt_out;
    logic        cnt_valid;
    logic        overflow;
    logic [15:0] acc_n;
    logic [23:0] acc_sum;
    logic [31:0] acc_sq;
    logic        done;

    int errors = 0;
    int checks = 0;
    int vcnt   = 0;
    logic [7:0] vals [0:63];

    always #10 clk = ~clk;

    beat_jitter_monitor uut (
        .clk_smp    (clk),
        .rst        (rst),
        .tst_clk    (tst_clk),
        .start      (start),
        .pop_target (pop_target),
        .cnt_out    (cnt_out),
        .cnt_valid  (cnt_valid),
        .overflow   (overflow),
        .acc_n      (acc_n),
        .acc_sum    (acc_sum),
        .acc_sq     (acc_sq),
        .done       (done)
    );

    always @(negedge clk) begin
        if (cnt_valid && vcnt < 64) begin
            vals[vcnt] = cnt_out;
            vcnt = vcnt + 1;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic seg(input int len);
        tst_clk = ~tst_clk;
        repeat (len) @(negedge clk);
    endtask

    task automatic kick(input int tgt);
        pop_target = 16'(tgt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        vcnt = 0;
    endtask

    task automatic t_reset;
        check("R1 cnt_out", cnt_out, 0);
        check("R1 cnt_valid", cnt_valid, 0);
        check("R1 overflow", overflow, 0);
        check("R1 acc_n", acc_n, 0);
        check("R1 acc_sum", acc_sum, 0);
        check("R1 acc_sq", acc_sq, 0);
        check("R1 done", done, 0);
    endtask

    task automatic t_basic;
        kick(3);
        seg(10); seg(12); seg(125); seg(3); seg(6);
        check("R2 first length", vals[0], 10);
        check("R2 second length", vals[1], 12);
        check("R2 third length", vals[2], 125);
        check("R3 strobe count", vcnt, 4);
        check("R6 acc_n", acc_n, 3);
        check("R6 acc_sum", acc_sum, 147);
        check("R6 acc_sq", acc_sq, 15869);
        check("R7 done", done, 1);
        check("R7 ignored sample shown", cnt_out, 3);
        check("R4 no overflow", overflow, 0);
    endtask

    task automatic t_saturate;
        kick(2);
        check("R5 done cleared", done, 0);
        check("R5 acc_n cleared", acc_n, 0);
        seg(5); seg(300); seg(20); seg(30); seg(4);
        check("R4 saturated length", vals[1], 255);
        check("R4 overflow set", overflow, 1);
        check("R4 acc_n skips saturated", acc_n, 2);
        check("R4 acc_sum", acc_sum, 25);
        check("R6 acc_sq", acc_sq, 425);
        check("R7 done", done, 1);
    endtask

    task automatic t_boundary;
        kick(2);
        check("R5 overflow cleared", overflow, 0);
        seg(5); seg(255); seg(4);
        check("R4 length 255", vals[1], 255);
        check("R4 overflow stays clear", overflow, 0);
        check("R4 acc_n", acc_n, 2);
        check("R4 acc_sum", acc_sum, 260);
        check("R4 acc_sq", acc_sq, 65050);
    endtask

    task automatic t_zero;
        kick(0);
        @(negedge clk);
        check("R8 done", done, 1);
        check("R8 acc_n", acc_n, 0);
        seg(6); seg(6); seg(6);
        check("R8 acc_sum stays zero", acc_sum, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; tst_clk = 1'b0; start = 1'b0; pop_target = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_saturate();
        t_boundary();
        t_zero();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule